// File: doc/BRIEF.md
# Lane Swizzle Permutation Unit

This unit moves 32-bit words between the 32 lanes of a SIMD vector. Each cycle it may accept a full lane vector together with a per-lane active mask, a mode code and the decoded parameters of that mode. For every destination lane it computes a source lane and copies that lane's word. The result is registered once and presented with a valid flag on the following cycle.

Five rearrangements are supported: a permute inside each aligned quad of lanes, a bitwise and/or/xor rewrite of the 5-bit lane number, a broadcast of one lane to every lane of its group, an exchange of neighbouring groups, and an in-group reversal. The parameters are checked against the selected mode. A combination that is not allowed raises an error flag, and the input vector then passes through unaltered so the caller can detect the problem without losing data. Lanes that are switched off, or that would read from a switched-off lane, produce zero.

Top module: `lane_swizzle_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and `out_err` are 0 after that edge.
- R2: `out_valid` is 1 in the cycle after a clock edge that sampled `in_valid` = 1, and 0 after an edge that sampled `in_valid` = 0.
- R3: Mode 0 (quad permute): lane i reads lane 4*floor(i/4) + s, where s = `quad_sel[2k+1:2k]` and k = i mod 4. This mode never flags an error.
- R4: Mode 1 (bitmask permute): lane i reads lane ((i AND `and_mask`) OR `or_mask`) XOR `xor_mask`, every term 5 bits wide. This mode never flags an error.
- R5: Mode 2 (broadcast): `grp_size` must be 2, 4, 8, 16 or 32 and `bcast_idx` must be less than `grp_size`. Lane i then reads lane grp_size*floor(i/grp_size) + bcast_idx.
- R6: Mode 3 (swap): `grp_size` must be 1, 2, 4, 8 or 16. Lane i then reads lane i XOR grp_size.
- R7: Mode 4 (reverse): `grp_size` must be 2, 4, 8, 16 or 32. Lane i then reads lane grp_size*floor(i/grp_size) + (grp_size-1-(i mod grp_size)).
- R8: For a legal request, destination lane i outputs zero when `in_active[i]` is 0 or when its source lane is inactive.
- R9: Mode codes 5 to 7, and any parameter outside the ranges given in R5 to R7, set `out_err` to 1 and make `out_data` equal to the captured `in_data` on every lane, whatever the mask. A legal request sets `out_err` to 0.
- R10: With every control input at zero (mode 0, `quad_sel` 0), each lane receives the word of the first lane of its quad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| in_data | input | 1024 | Lane words, lane n in bits [32n+31:32n] |
| in_active | input | 32 | Per-lane enable |
| mode | input | 3 | 0 quad, 1 bitmask, 2 broadcast, 3 swap, 4 reverse |
| quad_sel | input | 8 | Four 2-bit quad selectors |
| and_mask | input | 5 | Bitmask mode AND term |
| or_mask | input | 5 | Bitmask mode OR term |
| xor_mask | input | 5 | Bitmask mode XOR term |
| grp_size | input | 6 | Group size for broadcast, swap and reverse |
| bcast_idx | input | 5 | Broadcast lane within its group |
| out_valid | output | 1 | Result strobe |
| out_data | output | 1024 | Permuted lane words |
| out_err | output | 1 | Illegal request, data passed through |

## Verification
The bench concentrates on the edges of the parameter ranges: a broadcast index equal to the group size minus one, which is legal, and one equal to the group size, which is not; a swap size of 32; a reverse or broadcast size of 1; and a size that is not a power of two. A design that compared the index with the wrong bound, or accepted a size that has more than one bit set, would either produce a permutation where the error flag is expected or flag a request that is legal. Masks with lanes switched off catch a design that gates only on the destination or only on the source. Swap and reverse at their largest sizes reveal XOR terms that are truncated or off by one, which would show up as lanes taken from the wrong half of the vector.

// File: rtl/lsw_pkg.sv
package lsw_pkg;
  typedef enum logic [2:0] {
    MODE_QUAD    = 3'd0,
    MODE_BITMASK = 3'd1,
    MODE_BCAST   = 3'd2,
    MODE_SWAP    = 3'd3,
    MODE_REVERSE = 3'd4
  } lsw_mode_e;

  typedef struct packed {
    logic capture;
    logic bypass;
  } lsw_strobe_t;
endpackage

// File: rtl/lsw_ctrl.sv
module lsw_ctrl
  import lsw_pkg::*;
#(
  parameter int LANES = 32,
  localparam int IDXW = $clog2(LANES)
) (
  input  logic                       inValid,
  input  logic [2:0]                 mode,
  input  logic [7:0]                 quadSel,
  input  logic [IDXW-1:0]            andMask,
  input  logic [IDXW-1:0]            orMask,
  input  logic [IDXW-1:0]            xorMask,
  input  logic [IDXW:0]              grpSize,
  input  logic [IDXW-1:0]            bcastIdx,
  output lsw_strobe_t                strobe,
  output logic [LANES-1:0][IDXW-1:0] srcIdx
);
  logic [IDXW:0] sizeM1;
  logic          isPow2;
  logic          legal;
  lsw_mode_e     modeE;

  always_comb begin
    modeE  = lsw_mode_e'(mode);
    sizeM1 = grpSize - 1'b1;
    isPow2 = (grpSize != '0) && ((grpSize & sizeM1) == '0);
    case (modeE)
      MODE_QUAD, MODE_BITMASK: legal = 1'b1;
      MODE_BCAST:   legal = isPow2 && (grpSize >= 2) && (grpSize <= LANES)
                            && ({1'b0, bcastIdx} < grpSize);
      MODE_SWAP:    legal = isPow2 && (grpSize <= LANES / 2);
      MODE_REVERSE: legal = isPow2 && (grpSize >= 2) && (grpSize <= LANES);
      default:      legal = 1'b0;
    endcase
    strobe.capture = inValid;
    strobe.bypass  = !legal;
  end

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      logic [IDXW-1:0] li;
      li = IDXW'(l);
      case (modeE)
        MODE_QUAD:    srcIdx[l] = {li[IDXW-1:2], quadSel[2*li[1:0] +: 2]};
        MODE_BITMASK: srcIdx[l] = ((li & andMask) | orMask) ^ xorMask;
        MODE_BCAST:   srcIdx[l] = (li & ~sizeM1[IDXW-1:0]) | bcastIdx;
        MODE_SWAP:    srcIdx[l] = li ^ grpSize[IDXW-1:0];
        MODE_REVERSE: srcIdx[l] = li ^ sizeM1[IDXW-1:0];
        default:      srcIdx[l] = li;
      endcase
    end
  end
endmodule

// File: rtl/lsw_datapath.sv
module lsw_datapath
  import lsw_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(LANES)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  lsw_strobe_t                strobe,
  input  logic [LANES-1:0][IDXW-1:0] srcIdx,
  input  logic [LANES*DW-1:0]        inData,
  input  logic [LANES-1:0]           inActive,
  output logic                       outValid,
  output logic                       outErr,
  output logic [LANES*DW-1:0]        outData
);
  logic [LANES*DW-1:0] nextData;

  always_comb begin
    for (int l = 0; l < LANES; l++) begin
      if (strobe.bypass)
        nextData[l*DW +: DW] = inData[l*DW +: DW];
      else if (inActive[l] && inActive[srcIdx[l]])
        nextData[l*DW +: DW] = inData[int'(srcIdx[l])*DW +: DW];
      else
        nextData[l*DW +: DW] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outErr   <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        outErr  <= strobe.bypass;
        outData <= nextData;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : gLaneChk
    // R8
    idle_lane_zero_chk: assert property (@(posedge clk) disable iff (rst)
      outValid && !outErr && !$past(inActive[g]) |-> outData[g*DW +: DW] == '0);
  end
endmodule

// File: rtl/lane_swizzle_unit.sv
module lane_swizzle_unit
  import lsw_pkg::*;
#(
  parameter int LANES = 32,
  parameter int DW    = 32,
  localparam int IDXW = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [LANES*DW-1:0] in_data,
  input  logic [LANES-1:0]    in_active,
  input  logic [2:0]          mode,
  input  logic [7:0]          quad_sel,
  input  logic [IDXW-1:0]     and_mask,
  input  logic [IDXW-1:0]     or_mask,
  input  logic [IDXW-1:0]     xor_mask,
  input  logic [IDXW:0]       grp_size,
  input  logic [IDXW-1:0]     bcast_idx,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_data,
  output logic                out_err
);
  lsw_strobe_t                strobe;
  logic [LANES-1:0][IDXW-1:0] srcIdx;

  lsw_ctrl #(.LANES(LANES)) u_ctrl (
    .inValid(in_valid), .mode(mode), .quadSel(quad_sel),
    .andMask(and_mask), .orMask(or_mask), .xorMask(xor_mask),
    .grpSize(grp_size), .bcastIdx(bcast_idx),
    .strobe(strobe), .srcIdx(srcIdx)
  );

  lsw_datapath #(.LANES(LANES), .DW(DW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .srcIdx(srcIdx),
    .inData(in_data), .inActive(in_active),
    .outValid(out_valid), .outErr(out_err), .outData(out_data)
  );

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R9
  err_passthru_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_err |-> out_data == $past(in_data));
  // R9
  bad_mode_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (mode > 3'd4) |=> out_err);
  // R3
  quad_legal_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (mode == 3'd0) |=> !out_err);
  // R5
  bcast_range_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && (mode == 3'd2) && ({1'b0, bcast_idx} >= grp_size) |=> out_err);
endmodule

// File: tb/lane_swizzle_unit_tb.sv
`timescale 1ns/1ps
module lane_swizzle_unit_tb;
  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1023:0] in_data = '0;
  logic [31:0]   in_active = '1;
  logic [2:0]    mode = '0;
  logic [7:0]    quad_sel = '0;
  logic [4:0]    and_mask = '0, or_mask = '0, xor_mask = '0;
  logic [5:0]    grp_size = '0;
  logic [4:0]    bcast_idx = '0;
  logic          out_valid, out_err;
  logic [1023:0] out_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lane_swizzle_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_active(in_active), .mode(mode), .quad_sel(quad_sel),
    .and_mask(and_mask), .or_mask(or_mask), .xor_mask(xor_mask),
    .grp_size(grp_size), .bcast_idx(bcast_idx),
    .out_valid(out_valid), .out_data(out_data), .out_err(out_err)
  );

  function automatic bit isPow(int s);
    return (s == 1 || s == 2 || s == 4 || s == 8 || s == 16 || s == 32);
  endfunction

  function automatic bit expLegal();
    int s = int'(grp_size);
    case (int'(mode))
      0, 1: return 1;
      2: return isPow(s) && s >= 2 && int'(bcast_idx) < s;
      3: return isPow(s) && s <= 16;
      4: return isPow(s) && s >= 2;
      default: return 0;
    endcase
  endfunction

  function automatic int expSrc(int lane);
    int s = int'(grp_size);
    case (int'(mode))
      0: return (lane / 4) * 4 + ((int'(quad_sel) >> (2 * (lane % 4))) & 3);
      1: return ((lane & int'(and_mask)) | int'(or_mask)) ^ int'(xor_mask);
      2: return (lane / s) * s + int'(bcast_idx);
      3: return ((lane / s) % 2 == 0) ? lane + s : lane - s;
      default: return (lane / s) * s + (s - 1 - lane % s);
    endcase
  endfunction

  task automatic fail(string tag, string what, logic [63:0] act, logic [63:0] exp);
    errors++;
    $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
  endtask

  // inputs are set by the caller; one request is issued and checked
  task automatic run(string tag);
    logic          eLegal;
    logic [1023:0] eVec;
    eLegal = expLegal();
    for (int l = 0; l < 32; l++) begin
      if (!eLegal) eVec[l*32 +: 32] = in_data[l*32 +: 32];
      else begin
        int s = expSrc(l);
        eVec[l*32 +: 32] = (in_active[l] && in_active[s]) ? in_data[s*32 +: 32] : 32'h0;
      end
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    checks++;
    if (out_valid !== 1'b1) fail(tag, "R2 out_valid", 64'(out_valid), 64'd1);
    checks++;
    if (out_err !== !eLegal) fail(tag, "R9 out_err", 64'(out_err), 64'(!eLegal));
    checks++;
    if (out_data !== eVec) begin
      for (int l = 0; l < 32; l++)
        if (out_data[l*32 +: 32] !== eVec[l*32 +: 32]) begin
          fail(tag, $sformatf("data lane %0d", l), 64'(out_data[l*32 +: 32]),
               64'(eVec[l*32 +: 32]));
          break;
        end
    end
  endtask

  task automatic fillData();
    for (int l = 0; l < 32; l++) in_data[l*32 +: 32] = $urandom;
  endtask

  initial begin
    #(100000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    checks++;  // R1
    if (out_valid !== 1'b0 || out_err !== 1'b0)
      fail("R1", "reset outputs", 64'({out_valid, out_err}), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    checks++;  // R2 idle
    if (out_valid !== 1'b0) fail("R2", "idle out_valid", 64'(out_valid), 64'd0);

    // R10 all-zero controls
    fillData(); in_active = '1; mode = 0; quad_sel = 0;
    run("R10");
    @(negedge clk);
    checks++;  // R2 drop after one request
    if (out_valid !== 1'b0) fail("R2", "valid drop", 64'(out_valid), 64'd0);

    // R3 quad reversal 3,2,1,0
    fillData(); quad_sel = 8'b00_01_10_11; run("R3");
    // R4 force, keep, invert bits
    fillData(); mode = 1; and_mask = 5'b11100; or_mask = 5'b00001; xor_mask = 5'b10010;
    run("R4");
    // R5 edge indices
    fillData(); mode = 2; grp_size = 8; bcast_idx = 7; run("R5 idx max");
    fillData(); bcast_idx = 8; run("R5 idx over");
    fillData(); grp_size = 32; bcast_idx = 31; run("R5 full");
    fillData(); grp_size = 1; bcast_idx = 0; run("R5 size one");
    // R6 sizes
    fillData(); mode = 3; grp_size = 16; run("R6 max");
    fillData(); grp_size = 32; run("R6 too big");
    fillData(); grp_size = 1; run("R6 one");
    // R7 sizes
    fillData(); mode = 4; grp_size = 32; run("R7 full");
    fillData(); grp_size = 6; run("R7 non pow");
    // R8 inactive lanes
    fillData(); in_active = 32'h0F0F_00FF; mode = 4; grp_size = 16; run("R8");
    // R9 bad mode with sparse mask
    fillData(); mode = 6; run("R9 mode");

    // random mix
    for (int n = 0; n < 400; n++) begin
      fillData();
      mode      = 3'($urandom % 6);
      if ($urandom % 16 == 0) mode = 3'($urandom);
      in_active = $urandom | $urandom;
      quad_sel  = 8'($urandom);
      and_mask  = 5'($urandom); or_mask = 5'($urandom); xor_mask = 5'($urandom);
      grp_size  = ($urandom % 8 == 0) ? 6'($urandom) : 6'(1 << ($urandom % 6));
      bcast_idx = 5'($urandom % 32);
      if ($urandom % 2 == 0) bcast_idx = 5'($urandom % 32) % 5'(grp_size == 0 ? 1 : grp_size);
      run($sformatf("R%0d random", int'(mode) + 3));
      if ($urandom % 4 == 0) @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule